// File: doc/BRIEF.md
# Compensated Nanosecond Time Counter

This block keeps a 64-bit time value in nanoseconds. While it runs, it adds a small base step on every clock. When the reference clock is a little fast or slow against true time, software programs a second step value, the trim step, and states how often that step replaces the base step. Two mechanisms do this. A burst counter applies the trim step to a set number of consecutive ticks. A periodic counter applies it once every N ticks. Together they let the time rate be tuned in very fine steps while the value keeps moving, with no need to re-set the time.

Software reaches the block through a word-addressed 32-bit register port. The time value appears as two words. Reading the low word captures the high word at that same instant, so a 64-bit read done as two accesses is coherent. A write stages the high word first, and the write of the low word loads all 64 bits at once. A status flag records a carry out of the top bit. A separate wrap input lets an external match comparator return the time to zero, which makes the counter cycle at a programmed period.

Top module: `ns_time_counter`

## Requirements
- R1: Bit 0 of the config word (address 0) enables counting. While it is 0, the time value holds and neither compensation countdown moves.
- R2: Bits 7:4 of the config word hold the base step. When no compensation applies, each running clock adds exactly that step. A periodic setting of 0 means no periodic trim ticks.
- R3: Bits 19:8 of the config word hold the trim step. While the burst count (address 2) is non-zero, each running tick adds the trim step instead of the base step and lowers the burst count by one. A read of address 2 returns the remaining burst count.
- R4: A write to address 2 whose value is above 0xFFFFFF stores 0xFFFFFF.
- R5: Writing N > 0 to address 3 makes every Nth running tick after the write a trim tick, and the countdown then restarts. A read of address 3 returns N.
- R6: A read of address 4 returns bits 31:0 of the time value and captures bits 63:32 at the same edge. A later read of address 5 returns the captured bits, even if the time value has moved on since.
- R7: A write to address 5 only stages the upper half and leaves the time value unchanged. A write to address 4 loads {staged upper half, written lower half} as the new 64-bit value.
- R8: Bit 0 of the status word (address 1) is set when an addition carries out of bit 63. Writing 1 to it clears it and writing 0 has no effect. If a set and a clear fall on the same edge, the set wins.
- R9: While counting is enabled, a high wrap_in makes the time value 0 at that edge instead of adding a step. While counting is disabled, wrap_in has no effect.
- R10: A write to address 4 takes priority over both the step addition and wrap_in on the same edge.
- R11: A read returns its data on rdata one clock after the read edge, with rd_valid high for that one cycle. In the config word, only the fields of R1 to R3 read back, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| wrap_in | input | 1 | Return the time value to zero (external match pulse) |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Marks the cycle in which rdata holds a read result |

## Verification
The embedded properties assume one register access per clock, held for exactly one edge. They also assume wrap_in is a synchronous one-cycle pulse, and that software never sets a burst count and a periodic count so that they overlap in a way it then relies on. The stimulus drives every access on the falling edge, one strobe at a time, and stops counting before it reprograms a compensation setting. That keeps each expected value a closed formula in the number of running edges since a known load or enable. Wrap pulses are given both alone and together with a low-word write, so the priority order is exercised at the port.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CFG   = 3'd0,
      A_STAT  = 3'd1,
      A_BURST = 3'd2,
      A_EVERY = 3'd3,
      A_TLO   = 3'd4,
      A_THI   = 3'd5
   } ntc_addr_e;

endpackage

// File: rtl/ntc_step_sel.sv
module ntc_step_sel #(
   parameter int DATA_W  = 32,
   parameter int BASE_W  = 4,
   parameter int TRIM_W  = 12,
   parameter int BURST_W = 24,
   parameter int EVERY_W = 32,
   localparam int STEP_W = (BASE_W > TRIM_W) ? BASE_W : TRIM_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [BASE_W-1:0]  base_step,
   input  logic [TRIM_W-1:0]  trim_step,
   input  logic               burst_wr,
   input  logic               every_wr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [STEP_W-1:0]  step,
   output logic [BURST_W-1:0] burst_left,
   output logic [EVERY_W-1:0] every_n
);

   localparam logic [DATA_W-1:0] BURST_LIM = DATA_W'({BURST_W{1'b1}});

   logic [EVERY_W-1:0] every_left;
   logic [BURST_W-1:0] burst_in;
   logic [EVERY_W-1:0] every_in;
   logic               every_hit;
   logic               use_trim;

   assign burst_in  = (wdata > BURST_LIM) ? {BURST_W{1'b1}} : wdata[BURST_W-1:0];
   assign every_in  = wdata[EVERY_W-1:0];
   assign every_hit = run && (every_n != '0) && (every_left == '0);
   assign use_trim  = (burst_left != '0) || every_hit;
   assign step      = use_trim ? STEP_W'(trim_step) : STEP_W'(base_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         burst_left <= '0;
      end else if (burst_wr) begin
         burst_left <= burst_in;
      end else if (run && burst_left != '0) begin
         burst_left <= burst_left - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         every_n    <= '0;
         every_left <= '0;
      end else if (every_wr) begin
         every_n    <= every_in;
         every_left <= (every_in == '0) ? '0 : every_in - 1'b1;
      end else if (run && every_n != '0) begin
         every_left <= (every_left == '0) ? every_n - 1'b1 : every_left - 1'b1;
      end
   end

   p_burst_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && burst_left != '0 && !burst_wr) |=> burst_left == $past(burst_left) - 1'b1);

   p_every_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && every_n != '0 && every_left != '0 && !every_wr)
      |=> every_left == $past(every_left) - 1'b1);

   p_stop_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !every_wr && !burst_wr) |=> ($stable(every_left) && $stable(burst_left)));

endmodule

// File: rtl/ntc_accum.sv
module ntc_accum #(
   parameter int CNT_W  = 64,
   parameter int STEP_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [STEP_W-1:0] step,
   input  logic              wrap_req,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  count,
   output logic              carry
);

   logic [CNT_W:0] sum;

   assign sum   = {1'b0, count} + (CNT_W+1)'(step);
   assign carry = run && !load && !wrap_req && sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (run && wrap_req) begin
         count <= '0;
      end else if (run) begin
         count <= sum[CNT_W-1:0];
      end
   end

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load) |=> $stable(count));

   p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wrap_req && !load) |=> count == '0);

   p_load_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val));

endmodule

// File: rtl/ntc_readback.sv
module ntc_readback #(
   parameter int DATA_W = 32,
   parameter bit RD_REG = 1'b1,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  logic [ntc_pkg::ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]         cfg_word,
   input  logic [DATA_W-1:0]         stat_word,
   input  logic [DATA_W-1:0]         burst_word,
   input  logic [DATA_W-1:0]         every_word,
   input  logic [CNT_W-1:0]          count,
   output logic [DATA_W-1:0]         rdata,
   output logic                      rd_valid
);
   import ntc_pkg::*;

   logic [DATA_W-1:0] hi_shadow;
   logic [DATA_W-1:0] sel;

   always_comb begin
      unique case (addr)
         A_CFG:   sel = cfg_word;
         A_STAT:  sel = stat_word;
         A_BURST: sel = burst_word;
         A_EVERY: sel = every_word;
         A_TLO:   sel = count[DATA_W-1:0];
         A_THI:   sel = hi_shadow;
         default: sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_shadow <= '0;
      end else if (rd_en && addr == A_TLO) begin
         hi_shadow <= count[CNT_W-1:DATA_W];
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata    <= '0;
               rd_valid <= 1'b0;
            end else begin
               rd_valid <= rd_en;
               if (rd_en) rdata <= sel;
            end
         end
      end else begin : g_rd_comb
         assign rdata    = rd_en ? sel : '0;
         assign rd_valid = rd_en;
      end
   endgenerate

   p_shadow_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_TLO) |=> hi_shadow == $past(count[CNT_W-1:DATA_W]));

   p_shadow_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr == A_TLO) |=> $stable(hi_shadow));

endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
   parameter int DATA_W   = 32,
   parameter int BASE_W   = 4,
   parameter int TRIM_W   = 12,
   parameter int BURST_W  = 24,
   parameter int EVERY_W  = 32,
   parameter int BASE_LSB = 4,
   parameter bit RD_REG   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   input  logic        wrap_in,
   output logic [31:0] rdata,
   output logic        rd_valid
);
   import ntc_pkg::*;

   localparam int CNT_W    = 2 * DATA_W;
   localparam int TRIM_LSB = BASE_LSB + BASE_W;
   localparam int STEP_W   = (BASE_W > TRIM_W) ? BASE_W : TRIM_W;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("DATA_W must match the 32-bit register port");
      end
      if (BASE_LSB < 1 || TRIM_LSB + TRIM_W > DATA_W) begin : g_bad_fields
         $error("config fields do not fit in one word");
      end
      if (BURST_W >= DATA_W || EVERY_W > DATA_W || BASE_W < 1) begin : g_bad_counts
         $error("compensation widths out of range");
      end
   endgenerate

   logic                run_q;
   logic [BASE_W-1:0]   base_q;
   logic [TRIM_W-1:0]   trim_q;
   logic [DATA_W-1:0]   hi_stage;
   logic                ovf_q;
   logic [DATA_W-1:0]   cfg_word;
   logic [DATA_W-1:0]   stat_word;
   logic [STEP_W-1:0]   step;
   logic [BURST_W-1:0]  burst_left;
   logic [EVERY_W-1:0]  every_n;
   logic [CNT_W-1:0]    count;
   logic                acc_carry;
   logic                wr_cfg, wr_stat, wr_burst, wr_every, wr_lo, wr_hi;

   assign wr_cfg   = wr_en && addr == A_CFG;
   assign wr_stat  = wr_en && addr == A_STAT;
   assign wr_burst = wr_en && addr == A_BURST;
   assign wr_every = wr_en && addr == A_EVERY;
   assign wr_lo    = wr_en && addr == A_TLO;
   assign wr_hi    = wr_en && addr == A_THI;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         base_q <= '0;
         trim_q <= '0;
      end else if (wr_cfg) begin
         run_q  <= wdata[0];
         base_q <= wdata[BASE_LSB +: BASE_W];
         trim_q <= wdata[TRIM_LSB +: TRIM_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_stage <= '0;
      end else if (wr_hi) begin
         hi_stage <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (acc_carry) begin
         ovf_q <= 1'b1;
      end else if (wr_stat && wdata[0]) begin
         ovf_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_word                       = '0;
      cfg_word[0]                    = run_q;
      cfg_word[BASE_LSB +: BASE_W]   = base_q;
      cfg_word[TRIM_LSB +: TRIM_W]   = trim_q;
      stat_word                      = '0;
      stat_word[0]                   = ovf_q;
   end

   ntc_step_sel #(
      .DATA_W (DATA_W), .BASE_W (BASE_W), .TRIM_W (TRIM_W),
      .BURST_W(BURST_W), .EVERY_W(EVERY_W)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .base_step (base_q),
      .trim_step (trim_q),
      .burst_wr  (wr_burst),
      .every_wr  (wr_every),
      .wdata     (wdata),
      .step      (step),
      .burst_left(burst_left),
      .every_n   (every_n)
   );

   ntc_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .step    (step),
      .wrap_req(wrap_in),
      .load    (wr_lo),
      .load_val({hi_stage, wdata}),
      .count   (count),
      .carry   (acc_carry)
   );

   ntc_readback #(.DATA_W(DATA_W), .RD_REG(RD_REG)) u_rb (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .addr      (addr),
      .cfg_word  (cfg_word),
      .stat_word (stat_word),
      .burst_word(DATA_W'(burst_left)),
      .every_word(DATA_W'(every_n)),
      .count     (count),
      .rdata     (rdata),
      .rd_valid  (rd_valid)
   );

   p_flag_needs_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> $past(acc_carry));

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_stat) |=> ovf_q);

   p_hi_write_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !run_q) |=> $stable(count));

endmodule

// File: tb/tb_ns_time_counter.sv
module tb_ns_time_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wrap_in = 1'b0;
   logic [31:0] rdata;
   logic        rd_valid;

   ns_time_counter dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .wrap_in(wrap_in), .rdata(rdata), .rd_valid(rd_valid)
   );

   always #10 clk = ~clk;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t    sbq[$];
   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   int unsigned edge_n = 0;
   bit          done = 1'b0;

   always @(posedge clk) edge_n <= edge_n + 1;

   // monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sbq.size() == 0) begin
            n_bad++;
            $display("FAIL %s actual %h expected <nothing queued>", "R11", rdata);
         end else begin
            sb_item_t it;
            it = sbq.pop_front();
            n_cmp++;
            if (rdata !== it.exp) begin
               n_bad++;
               $display("FAIL %s actual %h expected %h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic op(input logic we, input logic re, input logic [2:0] a,
                     input logic [31:0] d, input logic wp);
      wr_en = we; rd_en = re; addr = a; wdata = d; wrap_in = wp;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; wrap_in = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      op(1'b1, 1'b0, a, d, 1'b0);
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      sb_item_t it;
      it.exp = e;
      it.tag = tag;
      sbq.push_back(it);
      op(1'b0, 1'b1, a, '0, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(1'b0, 1'b0, 3'd0, '0, 1'b0);
   endtask

   localparam logic [2:0] CFG = 3'd0, STAT = 3'd1, BURST = 3'd2, EVERY = 3'd3,
                          TLO = 3'd4, THI = 3'd5;

   initial begin
      int unsigned e, r, pl, s, w, n;
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R11, R1)
      rd(CFG, 32'h0, "R11 reset cfg");
      rd(STAT, 32'h0, "R8 reset status");
      rd(BURST, 32'h0, "R3 reset burst");
      rd(EVERY, 32'h0, "R5 reset period");
      rd(TLO, 32'h0, "R1 reset time lo");
      rd(THI, 32'h0, "R6 reset time hi");

      // R11: only defined config fields read back
      wr(CFG, 32'hFFFF_FFFE);
      rd(CFG, 32'h000F_FFF0, "R11 cfg field readback");
      wr(CFG, 32'h0);

      // R7: staging high half alone does not load
      wr(THI, 32'h1234_5678);
      rd(TLO, 32'h0, "R7 hi stage no load lo");
      rd(THI, 32'h0, "R7 hi stage no load hi");
      wr(TLO, 32'h9ABC_DEF0);
      idle(4);
      rd(TLO, 32'h9ABC_DEF0, "R1 stopped hold lo");
      rd(THI, 32'h1234_5678, "R7 64-bit load hi");

      // R2: base step only
      e = edge_n + 1;
      wr(CFG, 32'h31);
      idle(7);
      r = edge_n + 1;
      rd(TLO, 32'h9ABC_DEF0 + 3 * (r - e - 1), "R2 base step");
      rd(THI, 32'h1234_5678, "R2 base step hi");
      wr(CFG, 32'h0);

      // R3: burst compensation
      wr(THI, 32'h0);
      wr(TLO, 32'h0);
      wr(CFG, (32'd7 << 8) | (32'd2 << 4));
      wr(BURST, 32'd4);
      rd(BURST, 32'd4, "R3 burst readback");
      e = edge_n + 1;
      wr(CFG, (32'd7 << 8) | (32'd2 << 4) | 32'd1);
      idle(9);
      r = edge_n + 1;
      n = r - e - 1;
      rd(TLO, 7 * 4 + 2 * (n - 4), "R3 burst trim ticks");
      wr(CFG, 32'h0);
      rd(BURST, 32'd0, "R3 burst exhausted");

      // R4: burst write clamp
      wr(BURST, 32'h0100_0005);
      rd(BURST, 32'h00FF_FFFF, "R4 burst clamp");
      wr(BURST, 32'h0);

      // R5: periodic trim
      wr(TLO, 32'h0);
      wr(CFG, (32'd10 << 8) | (32'd1 << 4));
      wr(EVERY, 32'd5);
      rd(EVERY, 32'd5, "R5 period readback");
      e = edge_n + 1;
      wr(CFG, (32'd10 << 8) | (32'd1 << 4) | 32'd1);
      idle(12);
      r = edge_n + 1;
      n = r - e - 1;
      rd(TLO, n + 9 * (n / 5), "R5 every fifth tick trimmed");
      wr(CFG, 32'h0);
      wr(EVERY, 32'h0);

      // R6: low read captures high
      wr(THI, 32'h1);
      wr(CFG, 32'h11);
      pl = edge_n + 1;
      wr(TLO, 32'hFFFF_FFF0);
      idle(3);
      r = edge_n + 1;
      rd(TLO, 32'hFFFF_FFF0 + (r - pl - 1), "R6 lo before carry");
      idle(20);
      rd(THI, 32'h1, "R6 hi from capture");
      r = edge_n + 1;
      v = 64'h1_FFFF_FFF0 + 64'(r - pl - 1);
      rd(TLO, v[31:0], "R6 lo after carry");
      rd(THI, v[63:32], "R6 hi after carry");

      // R9: wrap while running
      w = edge_n + 1;
      op(1'b0, 1'b0, 3'd0, '0, 1'b1);
      idle(5);
      r = edge_n + 1;
      rd(TLO, r - w - 1, "R9 wrap to zero");
      rd(THI, 32'h0, "R9 wrap hi zero");

      // R10: load beats wrap
      pl = edge_n + 1;
      op(1'b1, 1'b0, TLO, 32'h500, 1'b1);
      idle(2);
      s = edge_n + 1;
      wr(CFG, 32'h0);
      v = 64'h1_0000_0500 + 64'(s - pl);
      rd(TLO, v[31:0], "R10 load over wrap lo");
      rd(THI, v[63:32], "R10 load over wrap hi");

      // R9: wrap ignored while stopped
      op(1'b0, 1'b0, 3'd0, '0, 1'b1);
      rd(TLO, v[31:0], "R9 wrap ignored stopped");

      // R8: overflow flag
      wr(THI, 32'hFFFF_FFFF);
      wr(TLO, 32'hFFFF_FFFE);
      rd(STAT, 32'h0, "R8 no flag before carry");
      e = edge_n + 1;
      wr(CFG, 32'h31);
      idle(2);
      s = edge_n + 1;
      wr(CFG, 32'h0);
      v = 64'hFFFF_FFFF_FFFF_FFFE + 64'(3 * (s - e));
      rd(STAT, 32'h1, "R8 flag set on carry");
      rd(TLO, v[31:0], "R8 wrapped lo");
      rd(THI, v[63:32], "R8 wrapped hi");
      wr(STAT, 32'h0);
      rd(STAT, 32'h1, "R8 write zero keeps flag");
      wr(STAT, 32'h1);
      rd(STAT, 32'h0, "R8 write one clears flag");

      idle(3);
      if (sbq.size() != 0) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", "R11 reads outstanding", sbq.size(), 0);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL %s actual %s expected %s", "watchdog", "hung", "finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule